// File: doc/BRIEF.md
# Parallel Panel Timing Generator

This block generates the line and frame timing for a parallel RGB panel. It runs on the pixel clock. It drives horizontal sync, vertical sync and a data-enable strobe, and it outputs the x/y coordinate of the pixel currently being shown. During active pixels it passes incoming pixel data to the panel. Everywhere else it substitutes a programmable blank colour. It also gives a one-clock frame-start pulse that can trigger a frame fetch, and a running frame count.

Configuration is static while the panel is enabled, except for the polarity bits. It arrives as packed 32-bit words, with the vertical count in the upper half and the horizontal count in the lower half:

- a total word;
- an active word;
- one porch word per axis;
- a 5-bit control word holding the panel enable and four polarity inversions.

Each axis is a small state machine with these states:

- `PH_OFF`: panel disabled.
- `PH_SYNC`: one unit of sync.
- `PH_LEAD`: the porch held in the low half of the porch word.
- `PH_ACT`: the active area.
- `PH_TRAIL`: the remaining units up to the programmed total.

The transitions are:

- **enable**: `PH_OFF` to `PH_SYNC`.
- **sync end**: `PH_SYNC` to `PH_LEAD`, or directly to `PH_ACT` when the lead porch is zero.
- **lead end**: `PH_LEAD` to `PH_ACT`.
- **active end**: `PH_ACT` to `PH_TRAIL`.
- **wrap**: any running state to `PH_SYNC` when the position reaches total minus one.
- **disable**: any state to `PH_OFF`.

The horizontal machine advances every clock. The vertical machine advances only on a horizontal wrap.

Top module: `panel_timing_gen`

## Requirements
- R1: While cfg_ctrl bit 0 (enable) is 0, the outputs are held as follows: hsync equals cfg_ctrl bit 2, vsync equals bit 3 and de equals bit 4; x_pos, y_pos, pix_out, frame_start, pclk_inv and frame_cnt are all 0.
- R2: When running, the horizontal position counts 0 to cfg_total[15:0]-1 and then wraps. Position 0 is sync, which is the only clock with raw hsync high. Positions 1 to L are the lead porch, where L = cfg_hporch[15:0]. The next cfg_active[15:0] positions are active, and the rest are trail porch.
- R3: The vertical line counts 0 to cfg_total[31:16]-1 and then wraps. The line advances on each horizontal wrap. Raw vsync is high for the whole of line 0. The lead porch is cfg_vporch[15:0] lines, followed by cfg_active[31:16] active lines.
- R4: Raw DE is high only when both axes are active. During raw DE, x_pos and y_pos count from 0 across the active area. Outside it they are 0.
- R5: Each output pin is its raw signal XOR an inversion bit: hsync uses cfg_ctrl bit 2, vsync uses bit 3 and de uses bit 4. pclk_inv equals cfg_ctrl bit 1 while running.
- R6: While running, pix_out equals pix_in during raw DE and equals cfg_blank otherwise.
- R7: frame_start is high for exactly one clock per frame. With cfg_trig_fall=0 (rising edge of raw vsync) it is high at position 0 of line 0. With cfg_trig_fall=1 (falling edge) it is high at position 0 of line 1.
- R8: frame_cnt increments by one in the clock after the first clock of each frame.
- R9: The clock after enable is first sampled high shows position 0 of line 0.
- R10: A lead porch of 0 is legal. The active area then begins at position 1 or line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_total | input | 32 | {vertical total, horizontal total} |
| cfg_active | input | 32 | {active lines, active pixels} |
| cfg_hporch | input | 32 | {trail porch, lead porch} in pixels |
| cfg_vporch | input | 32 | {trail porch, lead porch} in lines |
| cfg_ctrl | input | 5 | bit0 enable, bit1 pclk inv, bit2 hsync inv, bit3 vsync inv, bit4 de inv |
| cfg_trig_fall | input | 1 | frame-start on falling (1) or rising (0) raw vsync edge |
| cfg_blank | input | 24 | colour shown outside the active area |
| pix_in | input | 24 | pixel data for the current coordinate |
| hsync | output | 1 | horizontal sync pin |
| vsync | output | 1 | vertical sync pin |
| de | output | 1 | data-enable pin |
| pclk_inv | output | 1 | pixel clock inversion request |
| x_pos | output | 16 | active column |
| y_pos | output | 16 | active row |
| pix_out | output | 24 | pixel or blank colour |
| frame_start | output | 1 | frame trigger pulse |
| frame_cnt | output | 16 | frames started since enable |

## Verification
Every output except frame_cnt is decoded combinationally from the state registers. These outputs are therefore due in the first clock after the state changes: one clock after enable, and in the same cycle as pix_in and polarity changes. frame_cnt is registered and lags the frame's first clock by one. The bench's reference model advances its position integers at each rising edge, using the same input values the design sees. It compares every output at the falling edge, so the model and the design are always one register apart in the same way.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_SYNC  = 3'd1,
        PH_LEAD  = 3'd2,
        PH_ACT   = 3'd3,
        PH_TRAIL = 3'd4
    } phase_t;
endpackage

// File: rtl/ptg_axis.sv
module ptg_axis
    import ptg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    input  logic [W-1:0] total,
    input  logic [W-1:0] lead,
    input  logic [W-1:0] act,
    output phase_t       phase,
    output logic [W-1:0] pos,
    output logic         wrap
);
    logic [W-1:0] act_start;
    logic [W-1:0] act_end;
    logic [W-1:0] pos_inc;
    phase_t       phase_nxt;
    logic [W-1:0] pos_nxt;

    assign act_start = lead + W'(1);
    assign act_end   = act_start + act;
    assign pos_inc   = pos + W'(1);
    assign wrap      = (phase != PH_OFF) && step && (pos == total - W'(1));

    always_comb begin
        phase_nxt = phase;
        pos_nxt   = pos;
        unique case (phase)
            PH_OFF: begin
                phase_nxt = PH_SYNC;
                pos_nxt   = '0;
            end
            PH_SYNC, PH_LEAD, PH_ACT, PH_TRAIL: begin
                if (wrap) begin
                    phase_nxt = PH_SYNC;
                    pos_nxt   = '0;
                end else if (step) begin
                    pos_nxt = pos_inc;
                    unique case (phase)
                        PH_SYNC:  phase_nxt = (lead == '0) ? PH_ACT : PH_LEAD;
                        PH_LEAD:  if (pos_inc == act_start) phase_nxt = PH_ACT;
                        PH_ACT:   if (pos_inc == act_end) phase_nxt = PH_TRAIL;
                        default:  phase_nxt = PH_TRAIL;
                    endcase
                end
            end
            default: begin
                phase_nxt = PH_OFF;
                pos_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_OFF;
            pos   <= '0;
        end else if (!en) begin
            phase <= PH_OFF;
            pos   <= '0;
        end else begin
            phase <= phase_nxt;
            pos   <= pos_nxt;
        end
    end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2*W-1:0] cfg_total,
    input  logic [2*W-1:0] cfg_active,
    input  logic [2*W-1:0] cfg_hporch,
    input  logic [2*W-1:0] cfg_vporch,
    input  logic [4:0]    cfg_ctrl,
    input  logic          cfg_trig_fall,
    input  logic [CW-1:0] cfg_blank,
    input  logic [CW-1:0] pix_in,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pclk_inv,
    output logic [W-1:0]  x_pos,
    output logic [W-1:0]  y_pos,
    output logic [CW-1:0] pix_out,
    output logic          frame_start,
    output logic [W-1:0]  frame_cnt
);
    localparam int EN_B = 0, PCLK_B = 1, HS_B = 2, VS_B = 3, DE_B = 4;

    phase_t       h_phase, v_phase;
    logic [W-1:0] h_pos, v_pos;
    logic         h_wrap, v_wrap;
    logic         run, hs_raw, vs_raw, de_raw, first_clk;

    ptg_axis #(.W(W)) u_h (
        .clk(clk), .rst_n(rst_n), .en(cfg_ctrl[EN_B]), .step(1'b1),
        .total(cfg_total[W-1:0]), .lead(cfg_hporch[W-1:0]),
        .act(cfg_active[W-1:0]),
        .phase(h_phase), .pos(h_pos), .wrap(h_wrap)
    );

    ptg_axis #(.W(W)) u_v (
        .clk(clk), .rst_n(rst_n), .en(cfg_ctrl[EN_B]), .step(h_wrap),
        .total(cfg_total[2*W-1:W]), .lead(cfg_vporch[W-1:0]),
        .act(cfg_active[2*W-1:W]),
        .phase(v_phase), .pos(v_pos), .wrap(v_wrap)
    );

    always_comb begin
        run       = (h_phase != PH_OFF);
        hs_raw    = (h_phase == PH_SYNC);
        vs_raw    = (v_phase == PH_SYNC);
        de_raw    = (h_phase == PH_ACT) && (v_phase == PH_ACT);
        first_clk = hs_raw && vs_raw;
        hsync     = hs_raw ^ cfg_ctrl[HS_B];
        vsync     = vs_raw ^ cfg_ctrl[VS_B];
        de        = de_raw ^ cfg_ctrl[DE_B];
        pclk_inv  = run && cfg_ctrl[PCLK_B];
        x_pos     = de_raw ? (h_pos - cfg_hporch[W-1:0] - W'(1)) : '0;
        y_pos     = de_raw ? (v_pos - cfg_vporch[W-1:0] - W'(1)) : '0;
        if (!run)
            pix_out = '0;
        else if (de_raw)
            pix_out = pix_in;
        else
            pix_out = cfg_blank;
        if (cfg_trig_fall)
            frame_start = hs_raw && (v_pos == W'(1)) && (v_phase != PH_OFF);
        else
            frame_start = first_clk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            frame_cnt <= '0;
        else if (!cfg_ctrl[EN_B])
            frame_cnt <= '0;
        else if (first_clk)
            frame_cnt <= frame_cnt + W'(1);
    end
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
    parameter int W  = 16,
    parameter int CW = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2*W-1:0] cfg_active,
    input logic [4:0]     cfg_ctrl,
    input logic           cfg_trig_fall,
    input logic [CW-1:0]  pix_in,
    input logic           hsync,
    input logic           vsync,
    input logic           de,
    input logic [W-1:0]   x_pos,
    input logic [W-1:0]   y_pos,
    input logic [CW-1:0]  pix_out,
    input logic           frame_start,
    input logic [W-1:0]   frame_cnt
);
    logic h_act, v_act, d_act;
    assign h_act = hsync ^ cfg_ctrl[2];
    assign v_act = vsync ^ cfg_ctrl[3];
    assign d_act = de ^ cfg_ctrl[4];

    assert_sync_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_act && $stable(cfg_ctrl)) |=> (!h_act || !$stable(cfg_ctrl)));

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ctrl[0] |=> (x_pos == '0 && y_pos == '0 && frame_cnt == '0
                          && !frame_start && pix_out == '0));

    assert_coord_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        d_act |-> (x_pos < cfg_active[W-1:0] && y_pos < cfg_active[2*W-1:W]));

    assert_pixel_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        d_act |-> pix_out == pix_in);

    assert_trigger_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !cfg_trig_fall) |-> (h_act && v_act));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != $past(frame_cnt)) |->
            (frame_cnt == $past(frame_cnt) + W'(1) || frame_cnt == '0));
endmodule

bind panel_timing_gen ptg_checker #(.W(W), .CW(CW)) u_ptg_checker (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_ctrl(cfg_ctrl),
    .cfg_trig_fall(cfg_trig_fall), .pix_in(pix_in), .hsync(hsync),
    .vsync(vsync), .de(de), .x_pos(x_pos), .y_pos(y_pos),
    .pix_out(pix_out), .frame_start(frame_start), .frame_cnt(frame_cnt)
);

// File: tb/test_panel_timing_gen.sv
module test_panel_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_total, cfg_active, cfg_hporch, cfg_vporch;
    logic [4:0]  cfg_ctrl = 5'd0;
    logic        cfg_trig_fall = 1'b0;
    logic [23:0] cfg_blank = 24'hFF00FF;
    logic [23:0] pix_in = 24'd0;
    logic        hsync, vsync, de, pclk_inv, frame_start;
    logic [15:0] x_pos, y_pos, frame_cnt;
    logic [23:0] pix_out;

    int ht, hl, ha, htr, vt, vl, va, vtr;
    int on, hp, vp, fc;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign cfg_total  = {16'(vt), 16'(ht)};
    assign cfg_active = {16'(va), 16'(ha)};
    assign cfg_hporch = {16'(htr), 16'(hl)};
    assign cfg_vporch = {16'(vtr), 16'(vl)};

    panel_timing_gen i_panel_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_total(cfg_total), .cfg_active(cfg_active),
        .cfg_hporch(cfg_hporch), .cfg_vporch(cfg_vporch), .cfg_ctrl(cfg_ctrl),
        .cfg_trig_fall(cfg_trig_fall), .cfg_blank(cfg_blank), .pix_in(pix_in),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk_inv(pclk_inv),
        .x_pos(x_pos), .y_pos(y_pos), .pix_out(pix_out),
        .frame_start(frame_start), .frame_cnt(frame_cnt)
    );

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // reference model: advances on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n || !cfg_ctrl[0]) begin
            on = 0; hp = 0; vp = 0; fc = 0;
        end else begin
            if (on == 1 && hp == 0 && vp == 0) fc++;
            if (on == 0) begin
                on = 1; hp = 0; vp = 0;
            end else if (hp == ht - 1) begin
                hp = 0;
                vp = (vp == vt - 1) ? 0 : vp + 1;
            end else begin
                hp++;
            end
        end
    end

    // compare every output away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit de_r;
            de_r = (on == 1) && hp >= hl + 1 && hp <= hl + ha && vp >= vl + 1 && vp <= vl + va;
            if (on == 0) begin
                chk("R1", "pix_out idle", pix_out, 0);
                chk("R1", "x idle", x_pos, 0);
                chk("R1", "pclk idle", pclk_inv, 0);
            end
            chk("R2", "hsync", hsync, ((on == 1 && hp == 0) ? 1 : 0) ^ cfg_ctrl[2]);
            chk("R3", "vsync", vsync, ((on == 1 && vp == 0) ? 1 : 0) ^ cfg_ctrl[3]);
            chk("R4", "de", de, de_r ^ cfg_ctrl[4]);
            chk("R4", "x_pos", x_pos, de_r ? hp - hl - 1 : 0);
            chk("R4", "y_pos", y_pos, de_r ? vp - vl - 1 : 0);
            chk("R5", "pclk_inv", pclk_inv, (on == 1) && cfg_ctrl[1]);
            if (on == 1) chk("R6", "pix_out", pix_out, de_r ? pix_in : cfg_blank);
            chk("R7", "frame_start", frame_start,
                (on == 1 && hp == 0 && vp == (cfg_trig_fall ? 1 : 0)) ? 1 : 0);
            chk("R8", "frame_cnt", frame_cnt, fc);
        end
    end

    always @(negedge clk) pix_in <= pix_in + 24'h010203;

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        ht = 12; hl = 2; ha = 6; htr = 3;
        vt = 8;  vl = 1; va = 4; vtr = 2;
        cycles(4);
        rst_n = 1'b1;
        cycles(10);
        chk("R1", "hsync level while off", hsync, 0);
        cfg_ctrl = 5'b11100;
        cycles(3);
        chk("R1", "inverted idle hsync", hsync, 1);
        chk("R1", "inverted idle de", de, 1);
        chk("R1", "frame_cnt idle", frame_cnt, 0);
        cfg_ctrl = 5'b00001;
        cycles(300);
        cfg_ctrl = 5'b11111;          // R5 all inversions
        cycles(200);
        cfg_trig_fall = 1'b1;         // R7 falling edge trigger
        cycles(200);
        cfg_ctrl = 5'b00000;
        cycles(5);
        ht = 9; hl = 0; ha = 5; htr = 3;
        vt = 5; vl = 0; va = 3; vtr = 1;
        cfg_trig_fall = 1'b0;
        cfg_ctrl = 5'b00001;
        cycles(1);
        chk("R9", "first clock after enable hsync", hsync, 1);
        chk("R9", "first clock after enable vsync", vsync, 1);
        // R10: lead porch zero, active starts at position 1 on line 1
        while (!(hp == 1 && vp == 1)) @(negedge clk);
        chk("R10", "de at pos 1 line 1", de, 1);
        chk("R10", "x at first active", x_pos, 0);
        chk("R10", "y at first active", y_pos, 0);
        cycles(200);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule